// File: doc/BRIEF.md
# Multi-Row Activation Command Sequencer

This block generates a DRAM command and address stream that opens several rows of one subarray at once. It does this by compressing two timing gaps on purpose. A single start pulse launches a run. The block first fills every row of the selected row group with a known bit pattern, using ordinary write timing. It then issues three commands in a row: an activate to one row, a precharge that comes far earlier than the row-active minimum, and an activate to a second row before the precharge time has elapsed. Next it reads back the opened row burst by burst at normal timing, and it closes the bank with a nominal precharge.

The two compressed gaps are run-time inputs counted in controller cycles. All other gaps come from elaboration parameters and are never shortened. The whole fill, open and read run can be repeated a programmed number of times for signature collection. A count of zero selects a default of 100 repetitions. A one-cycle `done` pulse marks the end of the last repetition. The command output carries NOP on every cycle when no command is due.

Top module: `msa_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `cmd` is NOP (encoding 0), `busy` is 0 and `done` is 0. The command encodings are NOP=0, ACT=1, WR=2, RD=3 and PRE=4.
- R2: Let g be `grp_log`, with 0 clamped to 1 and values above 5 clamped to 5. Let S = 2^g. The fill phase handles rows `base`..`base`+S-1 in ascending order, where `base` is `row_a` with its low g bits cleared. Each row gets ACT (address = row), then `BURSTS` WR commands at columns 0, `BL`, 2·`BL`, …, then PRE (address 0). Every data bit of row i's writes equals `pattern[i]`.
- R3: In the fill phase, ACT to the first WR is `T_RCD` cycles and WR to WR is `T_CCD`. The PRE follows the last WR by the larger of `T_WR` and the remainder needed to reach `T_RAS` after the ACT. Each PRE is followed by the next ACT after `T_RP` cycles.
- R4: `T_RP` cycles after the last fill PRE comes ACT to `row_a`. PRE follows `short_ras` cycles after that ACT, and ACT to `row_b` follows `short_rp` cycles after the PRE.
- R5: A `short_ras` or `short_rp` value of 0 behaves as 1, which gives back-to-back commands.
- R6: After the second ACT, `BURSTS` RD commands follow at columns j·`BL`. The first comes after `T_RCD` and the rest are spaced by `T_CCD`. PRE comes after the larger of `T_RTP` and the `T_RAS` remainder.
- R7: The fill, open and read run executes `rep_cnt` times, or 100 times when `rep_cnt` is 0. The next run's first ACT comes `T_RP` cycles after the read PRE.
- R8: `done` is high for exactly one cycle, `T_RP` cycles after the final PRE. `busy` is 0 from that cycle onward.
- R9: A `start` pulse while `busy` is high has no effect on the addresses, the command count or the run.
- R10: `cmd` is NOP on every cycle without a due command, so the stream holds exactly the commands of R2–R7. `cmd_bank` equals the `bank` captured at start on every non-NOP command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, sampled when idle |
| row_a | input | ROW_W | First row to open; also selects the row group |
| row_b | input | ROW_W | Second row to open and the row that is read back |
| bank | input | BANK_W | Target bank |
| grp_log | input | 3 | log2 of the row group size (1..5) |
| pattern | input | 2^MAX_GLOG | Fill bit for each row index in the group |
| short_ras | input | GAP_W | Compressed ACT-to-PRE gap in cycles |
| short_rp | input | GAP_W | Compressed PRE-to-ACT gap in cycles |
| rep_cnt | input | REP_W | Repetition count, 0 selects 100 |
| cmd | output | 3 | Command code |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_addr | output | ROW_W | Row for ACT, column for WR/RD, 0 otherwise |
| cmd_wdata | output | DQ_W | Write data for WR |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The full command stream is compared entry by entry against a model of the expected stream, including the cycle gap before each command. Group sizes of 2, 4 and 32 show whether the group base masking and the row count follow `grp_log`. Alternating and half-split patterns show whether each row gets its own fill bit, and an out-of-range `grp_log` exercises the clamp. Compressed gaps of 2/3, 1/1 and 0/0 separate correct gap programming from the zero clamp. Repeat counts of 3 and 0 confirm the repetition loop and its default, and a start pulse injected mid-run confirms that a busy run ignores it.

// File: rtl/msa_pkg.sv
package msa_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_WR  = 3'd2,
    CMD_RD  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FACT,
    ST_FWR,
    ST_FPRE,
    ST_OACT1,
    ST_OPRE,
    ST_OACT2,
    ST_RRD,
    ST_RPRE,
    ST_FIN
  } st_e;
endpackage

// File: rtl/msa_gap_timer.sv
module msa_gap_timer #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [GAP_W-1:0] load_val,
  output logic             ready
);
  logic [GAP_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign ready = (cnt == '0);

  // R3
  gap_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> ready);
endmodule

// File: rtl/msa_ras_tracker.sv
module msa_ras_tracker #(
  parameter int T_RAS = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic act_issue,
  output logic ras_met
);
  localparam int CW = $clog2(T_RAS + 1);
  localparam logic [CW-1:0] RAS_L = CW'(T_RAS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= RAS_L;
    else if (act_issue)
      cnt <= CW'(1);
    else if (cnt < RAS_L)
      cnt <= cnt + 1'b1;
  end

  assign ras_met = (cnt >= RAS_L);

  // R3
  ras_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (ras_met && !act_issue) |=> ras_met);
endmodule

// File: rtl/msa_addr_gen.sv
module msa_addr_gen #(
  parameter int ROW_W    = 16,
  parameter int COL_W    = 10,
  parameter int MAX_GLOG = 5,
  parameter int BURSTS   = 8,
  parameter int BL       = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ROW_W-1:0]    row_src,
  input  logic [2:0]          glog,
  input  logic                row_clr,
  input  logic                row_adv,
  input  logic                bst_clr,
  input  logic                bst_adv,
  output logic [ROW_W-1:0]    init_row,
  output logic [COL_W-1:0]    col,
  output logic [MAX_GLOG-1:0] row_idx,
  output logic                last_row,
  output logic                last_bst
);
  localparam int BST_W = (BURSTS > 1) ? $clog2(BURSTS) : 1;

  logic [BST_W-1:0]    bcnt;
  logic [MAX_GLOG-1:0] ridx;
  logic [ROW_W-1:0]    gmask;

  always_ff @(posedge clk) begin
    if (rst) begin
      ridx <= '0;
      bcnt <= '0;
    end else begin
      if (row_clr)
        ridx <= '0;
      else if (row_adv)
        ridx <= ridx + 1'b1;
      if (bst_clr)
        bcnt <= '0;
      else if (bst_adv)
        bcnt <= bcnt + 1'b1;
    end
  end

  assign gmask    = (ROW_W'(1) << glog) - ROW_W'(1);
  assign init_row = (row_src & ~gmask) | ROW_W'(ridx);
  assign last_row = (ridx == gmask[MAX_GLOG-1:0]);
  assign last_bst = (bcnt == BST_W'(BURSTS - 1));
  assign col      = COL_W'(BL) * COL_W'(bcnt);
  assign row_idx  = ridx;

  // R2
  row_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    row_adv |-> !last_row);

  // R6
  bst_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    bst_adv |-> !last_bst);
endmodule

// File: rtl/msa_seq.sv
module msa_seq
  import msa_pkg::*;
#(
  parameter int ROW_W    = 16,
  parameter int COL_W    = 10,
  parameter int BANK_W   = 3,
  parameter int DQ_W     = 64,
  parameter int MAX_GLOG = 5,
  parameter int BURSTS   = 8,
  parameter int BL       = 8,
  parameter int GAP_W    = 8,
  parameter int REP_W    = 8,
  parameter int T_RCD    = 4,
  parameter int T_RAS    = 40,
  parameter int T_RP     = 5,
  parameter int T_CCD    = 4,
  parameter int T_WR     = 6,
  parameter int T_RTP    = 3,
  parameter int DEF_REP  = 100
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [ROW_W-1:0]         row_a,
  input  logic [ROW_W-1:0]         row_b,
  input  logic [BANK_W-1:0]        bank,
  input  logic [2:0]               grp_log,
  input  logic [(1<<MAX_GLOG)-1:0] pattern,
  input  logic [GAP_W-1:0]         short_ras,
  input  logic [GAP_W-1:0]         short_rp,
  input  logic [REP_W-1:0]         rep_cnt,
  output logic [2:0]               cmd,
  output logic [BANK_W-1:0]        cmd_bank,
  output logic [ROW_W-1:0]         cmd_addr,
  output logic [DQ_W-1:0]          cmd_wdata,
  output logic                     busy,
  output logic                     done
);
  localparam int PAT_W = 1 << MAX_GLOG;
  localparam logic [GAP_W-1:0] L_RCD = GAP_W'(T_RCD - 1);
  localparam logic [GAP_W-1:0] L_RP  = GAP_W'(T_RP - 1);
  localparam logic [GAP_W-1:0] L_CCD = GAP_W'(T_CCD - 1);
  localparam logic [GAP_W-1:0] L_WR  = GAP_W'(T_WR - 1);
  localparam logic [GAP_W-1:0] L_RTP = GAP_W'(T_RTP - 1);

  st_e st, nxt;

  // captured run settings
  logic [ROW_W-1:0]  ra_q, rb_q;
  logic [BANK_W-1:0] bank_q;
  logic [2:0]        glog_q;
  logic [PAT_W-1:0]  pat_q;
  logic [GAP_W-1:0]  sras_q, srp_q;
  logic [REP_W-1:0]  rep_left;

  // registered outputs
  cmd_e              cmd_q;
  logic [ROW_W-1:0]  addr_q;
  logic [BANK_W-1:0] cbank_q;
  logic [DQ_W-1:0]   wdata_q;
  logic              done_q;

  // next-cycle decisions
  cmd_e              c_nxt;
  logic [ROW_W-1:0]  a_nxt;
  logic              d_bit;
  logic              t_load;
  logic [GAP_W-1:0]  t_val;
  logic              act_iss;
  logic              latch, rep_dec, done_n;
  logic              row_clr, row_adv, bst_clr, bst_adv;

  // sub-block results
  logic                t_ready, ras_met;
  logic [ROW_W-1:0]    init_row;
  logic [COL_W-1:0]    col;
  logic [MAX_GLOG-1:0] row_idx;
  logic                last_row, last_bst;

  logic [2:0]       glog_cl;
  logic [GAP_W-1:0] sras_cl, srp_cl;
  logic [REP_W-1:0] rep_cl;

  always_comb begin
    if (grp_log == 3'd0)
      glog_cl = 3'd1;
    else if (grp_log > 3'(MAX_GLOG))
      glog_cl = 3'(MAX_GLOG);
    else
      glog_cl = grp_log;
    sras_cl = (short_ras == '0) ? GAP_W'(1) : short_ras;
    srp_cl  = (short_rp == '0) ? GAP_W'(1) : short_rp;
    rep_cl  = (rep_cnt == '0) ? REP_W'(DEF_REP) : rep_cnt;
  end

  msa_gap_timer #(.GAP_W(GAP_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .ready    (t_ready)
  );

  msa_ras_tracker #(.T_RAS(T_RAS)) u_ras (
    .clk       (clk),
    .rst       (rst),
    .act_issue (act_iss),
    .ras_met   (ras_met)
  );

  msa_addr_gen #(
    .ROW_W    (ROW_W),
    .COL_W    (COL_W),
    .MAX_GLOG (MAX_GLOG),
    .BURSTS   (BURSTS),
    .BL       (BL)
  ) u_addr (
    .clk      (clk),
    .rst      (rst),
    .row_src  (ra_q),
    .glog     (glog_q),
    .row_clr  (row_clr),
    .row_adv  (row_adv),
    .bst_clr  (bst_clr),
    .bst_adv  (bst_adv),
    .init_row (init_row),
    .col      (col),
    .row_idx  (row_idx),
    .last_row (last_row),
    .last_bst (last_bst)
  );

  always_comb begin
    nxt     = st;
    c_nxt   = CMD_NOP;
    a_nxt   = '0;
    d_bit   = 1'b0;
    t_load  = 1'b0;
    t_val   = '0;
    act_iss = 1'b0;
    latch   = 1'b0;
    rep_dec = 1'b0;
    done_n  = 1'b0;
    row_clr = 1'b0;
    row_adv = 1'b0;
    bst_clr = 1'b0;
    bst_adv = 1'b0;
    unique case (st)
      ST_IDLE: if (start) begin
        latch   = 1'b1;
        row_clr = 1'b1;
        bst_clr = 1'b1;
        nxt     = ST_FACT;
      end
      ST_FACT: if (t_ready) begin
        c_nxt   = CMD_ACT;
        a_nxt   = init_row;
        act_iss = 1'b1;
        t_load  = 1'b1;
        t_val   = L_RCD;
        nxt     = ST_FWR;
      end
      ST_FWR: if (t_ready) begin
        c_nxt  = CMD_WR;
        a_nxt  = ROW_W'(col);
        d_bit  = pat_q[row_idx];
        t_load = 1'b1;
        if (last_bst) begin
          t_val   = L_WR;
          bst_clr = 1'b1;
          nxt     = ST_FPRE;
        end else begin
          t_val   = L_CCD;
          bst_adv = 1'b1;
        end
      end
      ST_FPRE: if (t_ready && ras_met) begin
        c_nxt  = CMD_PRE;
        t_load = 1'b1;
        t_val  = L_RP;
        if (last_row) begin
          row_clr = 1'b1;
          nxt     = ST_OACT1;
        end else begin
          row_adv = 1'b1;
          nxt     = ST_FACT;
        end
      end
      ST_OACT1: if (t_ready) begin
        c_nxt   = CMD_ACT;
        a_nxt   = ra_q;
        act_iss = 1'b1;
        t_load  = 1'b1;
        t_val   = sras_q - 1'b1;
        nxt     = ST_OPRE;
      end
      ST_OPRE: if (t_ready) begin
        c_nxt  = CMD_PRE;
        t_load = 1'b1;
        t_val  = srp_q - 1'b1;
        nxt    = ST_OACT2;
      end
      ST_OACT2: if (t_ready) begin
        c_nxt   = CMD_ACT;
        a_nxt   = rb_q;
        act_iss = 1'b1;
        t_load  = 1'b1;
        t_val   = L_RCD;
        nxt     = ST_RRD;
      end
      ST_RRD: if (t_ready) begin
        c_nxt  = CMD_RD;
        a_nxt  = ROW_W'(col);
        t_load = 1'b1;
        if (last_bst) begin
          t_val   = L_RTP;
          bst_clr = 1'b1;
          nxt     = ST_RPRE;
        end else begin
          t_val   = L_CCD;
          bst_adv = 1'b1;
        end
      end
      ST_RPRE: if (t_ready && ras_met) begin
        c_nxt  = CMD_PRE;
        t_load = 1'b1;
        t_val  = L_RP;
        if (rep_left == REP_W'(1)) begin
          nxt = ST_FIN;
        end else begin
          rep_dec = 1'b1;
          row_clr = 1'b1;
          nxt     = ST_FACT;
        end
      end
      ST_FIN: if (t_ready) begin
        done_n = 1'b1;
        nxt    = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cmd_q    <= CMD_NOP;
      addr_q   <= '0;
      cbank_q  <= '0;
      wdata_q  <= '0;
      done_q   <= 1'b0;
      ra_q     <= '0;
      rb_q     <= '0;
      bank_q   <= '0;
      glog_q   <= 3'd1;
      pat_q    <= '0;
      sras_q   <= GAP_W'(1);
      srp_q    <= GAP_W'(1);
      rep_left <= '0;
    end else begin
      st      <= nxt;
      cmd_q   <= c_nxt;
      addr_q  <= a_nxt;
      cbank_q <= (c_nxt != CMD_NOP) ? bank_q : '0;
      wdata_q <= (c_nxt == CMD_WR) ? {DQ_W{d_bit}} : '0;
      done_q  <= done_n;
      if (latch) begin
        ra_q     <= row_a;
        rb_q     <= row_b;
        bank_q   <= bank;
        glog_q   <= glog_cl;
        pat_q    <= pattern;
        sras_q   <= sras_cl;
        srp_q    <= srp_cl;
        rep_left <= rep_cl;
      end else if (rep_dec) begin
        rep_left <= rep_left - 1'b1;
      end
    end
  end

  assign cmd       = cmd_q;
  assign cmd_bank  = cbank_q;
  assign cmd_addr  = addr_q;
  assign cmd_wdata = wdata_q;
  assign busy      = (st != ST_IDLE);
  assign done      = done_q;

  // R9
  start_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(ra_q) && $stable(rb_q) && $stable(rep_left)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R10
  idle_nop_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == ST_IDLE) |-> (cmd_q == CMD_NOP));

  // R3
  pre_ras_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_PRE && ($past(st) == ST_FPRE || $past(st) == ST_RPRE)) |-> ras_met);

  // R7
  rep_live_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (rep_left != '0));
endmodule

// File: tb/sim_msa_seq.sv
module sim_msa_seq;
  localparam int ROW_W = 16, COL_W = 10, BANK_W = 3, DQ_W = 64, MAX_GLOG = 5;
  localparam int BURSTS = 8, BL = 8, GAP_W = 8, REP_W = 8;
  localparam int T_RCD = 4, T_RAS = 40, T_RP = 5, T_CCD = 4, T_WR = 6, T_RTP = 3;
  localparam int SPAN  = T_RCD + (BURSTS - 1) * T_CCD;
  localparam int PRE_F = (T_WR > T_RAS - SPAN) ? T_WR : T_RAS - SPAN;
  localparam int PRE_R = (T_RTP > T_RAS - SPAN) ? T_RTP : T_RAS - SPAN;
  localparam int LOGN  = 4096;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [ROW_W-1:0] row_a = '0, row_b = '0;
  logic [BANK_W-1:0] bank = '0;
  logic [2:0] grp_log = 3'd1;
  logic [31:0] pattern = '0;
  logic [GAP_W-1:0] short_ras = 8'd1, short_rp = 8'd1;
  logic [REP_W-1:0] rep_cnt = 8'd1;
  logic [2:0] cmd;
  logic [BANK_W-1:0] cmd_bank;
  logic [ROW_W-1:0] cmd_addr;
  logic [DQ_W-1:0] cmd_wdata;
  logic busy, done;

  always #4 clk = ~clk;

  msa_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .DQ_W(DQ_W), .MAX_GLOG(MAX_GLOG),
    .BURSTS(BURSTS), .BL(BL), .GAP_W(GAP_W), .REP_W(REP_W), .T_RCD(T_RCD),
    .T_RAS(T_RAS), .T_RP(T_RP), .T_CCD(T_CCD), .T_WR(T_WR), .T_RTP(T_RTP),
    .DEF_REP(100)
  ) u0 (
    .clk(clk), .rst(rst), .start(start), .row_a(row_a), .row_b(row_b),
    .bank(bank), .grp_log(grp_log), .pattern(pattern), .short_ras(short_ras),
    .short_rp(short_rp), .rep_cnt(rep_cnt), .cmd(cmd), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  int cyc = 0, lg_n = 0, done_cnt = 0, done_cyc = 0, ek = 0;
  int lg_cmd [LOGN];
  int lg_addr[LOGN];
  int lg_bank[LOGN];
  int lg_d   [LOGN];
  int lg_cyc [LOGN];

  // command stream monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (cmd != 3'd0 && lg_n < LOGN) begin
        lg_cmd[lg_n]  = int'(cmd);
        lg_addr[lg_n] = int'(cmd_addr);
        lg_bank[lg_n] = int'(cmd_bank);
        lg_d[lg_n]    = (cmd_wdata == '0) ? 0 : ((cmd_wdata == '1) ? 1 : 2);
        lg_cyc[lg_n]  = cyc;
        lg_n++;
      end
      if (done) begin
        done_cnt++;
        done_cyc = cyc;
      end
    end
  end

  task automatic chk(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // compare the next logged command against one expected entry
  task automatic ex(string rq, int c, int a, int d, int gap, int bk);
    if (ek >= lg_n) begin
      chk({rq, " missing command"}, -1, c);
    end else begin
      chk({rq, " cmd"}, lg_cmd[ek], c);
      chk({rq, " addr"}, lg_addr[ek], a);
      chk("R10 bank", lg_bank[ek], bk);
      if (d >= 0) chk({rq, " data"}, lg_d[ek], d);
      if (gap > 0 && ek > 0) chk({rq, " gap"}, lg_cyc[ek] - lg_cyc[ek-1], gap);
    end
    ek++;
  endtask

  task automatic run_case(string tag, int g, int ra, int rb, int bk, logic [31:0] pat,
                          int sras, int srp, int rep, bit poke);
    int ge, sz, base, nrep, sr, sp;
    lg_n = 0; done_cnt = 0; ek = 0;
    @(negedge clk);
    row_a = ROW_W'(ra); row_b = ROW_W'(rb); bank = BANK_W'(bk);
    grp_log = 3'(g); pattern = pat; short_ras = GAP_W'(sras);
    short_rp = GAP_W'(srp); rep_cnt = REP_W'(rep); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      // R9: a start with other settings while busy
      row_a = ROW_W'(ra ^ 16'h0F00); row_b = ROW_W'(rb ^ 16'h00F0);
      rep_cnt = 8'd7; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_cnt == 0) @(negedge clk);
    repeat (T_RP + 12) @(negedge clk);

    ge   = (g == 0) ? 1 : ((g > 5) ? 5 : g);
    sz   = 1 << ge;
    base = ra & ~(sz - 1) & 16'hFFFF;
    nrep = (rep == 0) ? 100 : rep;
    sr   = (sras == 0) ? 1 : sras;
    sp   = (srp == 0) ? 1 : srp;
    for (int r = 0; r < nrep; r++) begin
      for (int i = 0; i < sz; i++) begin
        ex("R2", 1, base + i, -1, (r == 0 && i == 0) ? 0 : T_RP, bk);
        for (int j = 0; j < BURSTS; j++)
          ex("R3", 2, j * BL, int'(pat[i]), (j == 0) ? T_RCD : T_CCD, bk);
        ex("R3", 4, 0, -1, PRE_F, bk);
      end
      ex("R4", 1, ra, -1, T_RP, bk);
      ex("R4 R5", 4, 0, -1, sr, bk);
      ex("R4 R5", 1, rb, -1, sp, bk);
      for (int j = 0; j < BURSTS; j++)
        ex("R6", 3, j * BL, -1, (j == 0) ? T_RCD : T_CCD, bk);
      ex("R6", 4, 0, -1, PRE_R, bk);
    end
    chk({tag, " R7 R10 command total"}, lg_n, ek);
    chk({tag, " R8 done count"}, done_cnt, 1);
    if (lg_n > 0) chk({tag, " R8 done gap"}, done_cyc - lg_cyc[lg_n-1], T_RP);
    chk({tag, " R8 busy low"}, int'(busy), 0);
    chk({tag, " R10 idle nop"}, int'(cmd), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 cmd in reset", int'(cmd), 0);
    chk("R1 busy in reset", int'(busy), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cmd after reset", int'(cmd), 0);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 done after reset", int'(done), 0);
  endtask

  task automatic t_quad();     // R2 R3 R4 R6 R8: group of 4, alternating fill
    run_case("quad", 2, 16'h1235, 16'h1236, 3, 32'h0000_0005, 2, 3, 1, 1'b0);
  endtask

  task automatic t_wide();     // R2: group of 32, half-split fill, 1/1 gaps
    run_case("wide", 5, 16'h00BF, 16'h00A0, 6, 32'hFFFF_0000, 1, 1, 1, 1'b0);
  endtask

  task automatic t_zero_gap(); // R5 R7: zero gaps clamp to 1, three runs
    run_case("zgap", 1, 16'h4001, 16'h4000, 1, 32'h0000_0002, 0, 0, 3, 1'b0);
  endtask

  task automatic t_clamp();    // R2: grp_log 0 acts as 1
    run_case("clamp", 0, 16'h0777, 16'h0776, 2, 32'h0000_0001, 3, 2, 1, 1'b0);
  endtask

  task automatic t_busy();     // R9: start while busy ignored
    run_case("busy", 1, 16'h2222, 16'h2223, 5, 32'h0000_0001, 2, 2, 1, 1'b1);
  endtask

  task automatic t_default();  // R7: rep 0 selects 100
    run_case("defrep", 1, 16'h0010, 16'h0011, 0, 32'h0000_0001, 1, 2, 0, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_quad();
    t_wide();
    t_zero_gap();
    t_clamp();
    t_busy();
    t_default();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule